// File: doc/BRIEF.md
# Crate-Bus Byte FIFO Port with Service Request

This block sits between an instrument crate's command bus and a serial link engine. It holds two independent byte buffers. Bytes written by the crate go into the outbound buffer and are handed to the link through a simple pop handshake. Bytes delivered by the link go into the inbound buffer, where crate read commands drain them. Between them the two buffers let a full buffer's worth of bytes sit in each direction before either side has to wait.

Every bus command gets a registered response one cycle later. The response carries an accept flag (Q), which is withheld whenever the command cannot be carried out. A status read explains why Q was withheld. A service-request output (LAM) tells the crate controller that data has arrived in a receive buffer that was empty. A single reply-timeout or parity event from the link is held in the status until the next status read. While the timeout is held, writes are refused.

Top module: `crate_fifo_port`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rsp_valid and lam are 0, tx_avail is 0 and rx_ready is 1.
- R2: A command with function 16 and subaddress 0 pushes bits [7:0] of cmd_wdata into the transmit buffer. One cycle later it answers with rsp_valid=1, rsp_q=1 and rsp_rdata=0. tx_avail is 1 whenever the transmit buffer holds data. tx_data shows the oldest byte, and a tx_pop while tx_avail=1 removes that byte.
- R3: A function-16 write to a full transmit buffer answers rsp_q=0 and leaves the buffer contents unchanged. A status read then reports bit 0 as 1.
- R4: A command with function 0 and subaddress 0 returns the oldest received byte in rsp_rdata[7:0] with rsp_q=1 and removes it. If the receive buffer is empty, the answer is rsp_q=0 with rsp_rdata=0.
- R5: A command with function 1 and subaddress 0 answers rsp_q=1. rsp_rdata holds the status: bit0 tx full, bit1 tx empty, bit2 rx empty, bit3 rx full, bit4 reply timeout, bit5 parity error, and all other bits 0. The status reflects the state before this command takes effect.
- R6: lam becomes 1 in the cycle after rx_push is accepted into an empty receive buffer. A push into a non-empty buffer does not set it. A function-0 read answered with Q clears lam, even if bytes remain in the buffer.
- R7: A link_timeout pulse sets status bit 4. While bit 4 is set, function-16 writes answer rsp_q=0 and are not stored. A status read reports the bit and then clears it, after which writes are accepted again.
- R8: A link_parity_err pulse sets status bit 5, which is cleared by the next status read. If a pulse and a status read happen in the same cycle, the bit stays set.
- R9: A push and a pop on the same buffer in the same cycle both take effect. Byte order is kept and the occupancy does not change.
- R10: Any command other than (16,0), (0,0) or (1,0) answers rsp_valid=1, rsp_q=0 and rsp_rdata=0, and changes no state.
- R11: Each buffer accepts exactly FIFO_DEPTH bytes. rx_ready is 0 while the receive buffer is full, and an rx_push at that time is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | A bus command is presented this cycle |
| cmd_func | input | 5 | Function code |
| cmd_sub | input | 4 | Subaddress |
| cmd_wdata | input | BUS_W (24) | Write lines; the low 8 bits are used |
| rsp_valid | output | 1 | Response to the previous cycle's command |
| rsp_q | output | 1 | Command accepted |
| rsp_rdata | output | BUS_W (24) | Read lines: data byte or status |
| lam | output | 1 | Service request: data arrived in an empty receive buffer |
| tx_avail | output | 1 | Transmit buffer holds data |
| tx_data | output | 8 | Oldest transmit byte |
| tx_pop | input | 1 | Link takes tx_data |
| rx_push | input | 1 | Link delivers a byte |
| rx_data | input | 8 | Delivered byte |
| rx_ready | output | 1 | Receive buffer has room |
| link_timeout | input | 1 | Reply timeout event from the link |
| link_parity_err | input | 1 | Parity error event from the link |

## Verification
The corners that are hardest to reach from the ports are those at the full boundary. A bus write hitting a transmit buffer of FIFO_DEPTH bytes, and a link push hitting a full receive buffer while a read drains it in the same cycle, both need more than a thousand set-up cycles that random traffic would practically never produce. Directed phases therefore fill each buffer completely and probe the refused write, the dropped push and the simultaneous push and pop. Random traffic with a fixed seed then mixes the commands, the link events and the pops against a queue model in the bench.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
  localparam logic [4:0] FN_READ   = 5'd0;
  localparam logic [4:0] FN_STATUS = 5'd1;
  localparam logic [4:0] FN_WRITE  = 5'd16;
  localparam logic [3:0] SUB_DATA  = 4'd0;

  localparam int ST_TX_FULL  = 0;
  localparam int ST_TX_EMPTY = 1;
  localparam int ST_RX_EMPTY = 2;
  localparam int ST_RX_FULL  = 3;
  localparam int ST_TIMEOUT  = 4;
  localparam int ST_PARITY   = 5;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_READ,
    CMD_STATUS
  } cmd_kind_e;
endpackage

// File: rtl/cfp_cmd_decode.sv
module cfp_cmd_decode
  import cfp_pkg::*;
(
  input  logic       valid,
  input  logic [4:0] func,
  input  logic [3:0] sub,
  output cmd_kind_e  kind
);
  always_comb begin
    kind = CMD_NONE;
    if (valid && sub == SUB_DATA) begin
      unique case (func)
        FN_WRITE:  kind = CMD_WRITE;
        FN_READ:   kind = CMD_READ;
        FN_STATUS: kind = CMD_STATUS;
        default:   kind = CMD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/cfp_fifo.sv
module cfp_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty,
  output logic             push_ok,
  output logic             pop_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rptr_q];

  always_comb begin
    wptr_d = push_ok ? bump(wptr_q) : wptr_q;
    rptr_d = pop_ok  ? bump(rptr_q) : rptr_q;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end
endmodule

// File: rtl/cfp_flags.sv
module cfp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_timeout,
  input  logic set_parity,
  input  logic status_read,
  input  logic lam_set,
  input  logic lam_clr,
  output logic timeout_q,
  output logic parity_q,
  output logic lam_q
);
  logic timeout_d, parity_d, lam_d;

  always_comb begin
    timeout_d = timeout_q;
    parity_d  = parity_q;
    lam_d     = lam_q;
    if (status_read) begin
      timeout_d = 1'b0;
      parity_d  = 1'b0;
    end
    if (set_timeout) timeout_d = 1'b1;
    if (set_parity)  parity_d  = 1'b1;
    if (lam_clr)     lam_d     = 1'b0;
    if (lam_set)     lam_d     = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= 1'b0;
      parity_q  <= 1'b0;
      lam_q     <= 1'b0;
    end else begin
      timeout_q <= timeout_d;
      parity_q  <= parity_d;
      lam_q     <= lam_d;
    end
  end
endmodule

// File: rtl/crate_fifo_port.sv
module crate_fifo_port
  import cfp_pkg::*;
#(
  parameter int BUS_W      = 24,
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [4:0]        cmd_func,
  input  logic [3:0]        cmd_sub,
  input  logic [BUS_W-1:0]  cmd_wdata,
  output logic              rsp_valid,
  output logic              rsp_q,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              lam,
  output logic              tx_avail,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_pop,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  input  logic              link_timeout,
  input  logic              link_parity_err
);
  cmd_kind_e         kind_w;
  logic              tx_full_w, tx_empty_w, tx_push_ok_w, tx_pop_ok_w;
  logic              rx_full_w, rx_empty_w, rx_push_ok_w, rx_pop_ok_w;
  logic [DATA_W-1:0] rx_head_w;
  logic              to_flag_w, pe_flag_w;
  logic              wr_try_w, rd_try_w, st_rd_w;
  logic [BUS_W-1:0]  status_w;
  logic              rsp_valid_d, rsp_q_d;
  logic [BUS_W-1:0]  rsp_data_d;

  cfp_cmd_decode u_dec (
    .valid (cmd_valid),
    .func  (cmd_func),
    .sub   (cmd_sub),
    .kind  (kind_w)
  );

  assign wr_try_w = (kind_w == CMD_WRITE) & ~to_flag_w;
  assign rd_try_w = (kind_w == CMD_READ);
  assign st_rd_w  = (kind_w == CMD_STATUS);

  cfp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_try_w),
    .push_data (cmd_wdata[DATA_W-1:0]),
    .pop       (tx_pop),
    .head      (tx_data),
    .full      (tx_full_w),
    .empty     (tx_empty_w),
    .push_ok   (tx_push_ok_w),
    .pop_ok    (tx_pop_ok_w)
  );

  cfp_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (rx_push),
    .push_data (rx_data),
    .pop       (rd_try_w),
    .head      (rx_head_w),
    .full      (rx_full_w),
    .empty     (rx_empty_w),
    .push_ok   (rx_push_ok_w),
    .pop_ok    (rx_pop_ok_w)
  );

  cfp_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_timeout (link_timeout),
    .set_parity  (link_parity_err),
    .status_read (st_rd_w),
    .lam_set     (rx_push_ok_w & rx_empty_w),
    .lam_clr     (rx_pop_ok_w),
    .timeout_q   (to_flag_w),
    .parity_q    (pe_flag_w),
    .lam_q       (lam)
  );

  assign tx_avail = ~tx_empty_w;
  assign rx_ready = ~rx_full_w;

  always_comb begin
    status_w              = '0;
    status_w[ST_TX_FULL]  = tx_full_w;
    status_w[ST_TX_EMPTY] = tx_empty_w;
    status_w[ST_RX_EMPTY] = rx_empty_w;
    status_w[ST_RX_FULL]  = rx_full_w;
    status_w[ST_TIMEOUT]  = to_flag_w;
    status_w[ST_PARITY]   = pe_flag_w;
  end

  always_comb begin
    rsp_valid_d = cmd_valid;
    rsp_q_d     = 1'b0;
    rsp_data_d  = '0;
    unique case (kind_w)
      CMD_WRITE:  rsp_q_d = tx_push_ok_w;
      CMD_READ: begin
        rsp_q_d = rx_pop_ok_w;
        if (rx_pop_ok_w) rsp_data_d = BUS_W'(rx_head_w);
      end
      CMD_STATUS: begin
        rsp_q_d    = 1'b1;
        rsp_data_d = status_w;
      end
      default:    rsp_q_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_valid_d;
      rsp_q     <= rsp_q_d;
      rsp_rdata <= rsp_data_d;
    end
  end

  wire unused_ok = tx_pop_ok_w;
endmodule

// File: rtl/cfp_checker.sv
module cfp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [4:0] cmd_func,
  input logic [3:0] cmd_sub,
  input logic       rsp_valid,
  input logic       rsp_q,
  input logic       lam,
  input logic       tx_avail,
  input logic       rx_push,
  input logic       rx_empty,
  input logic       to_flag
);
  logic is_wr, is_rd, is_st, is_legal;
  assign is_wr    = cmd_valid && cmd_func == 5'd16 && cmd_sub == 4'd0;
  assign is_rd    = cmd_valid && cmd_func == 5'd0  && cmd_sub == 4'd0;
  assign is_st    = cmd_valid && cmd_func == 5'd1  && cmd_sub == 4'd0;
  assign is_legal = is_wr || is_rd || is_st;

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);

  p_tx_avail_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(is_wr) && rsp_q |-> tx_avail);

  p_empty_read_noq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd && rx_empty |=> !rsp_q);

  p_status_always_q_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_st |=> rsp_q);

  p_lam_on_first_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_empty |=> lam);

  p_timeout_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr && to_flag |=> !rsp_q);

  p_illegal_noq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !is_legal |=> rsp_valid && !rsp_q);
endmodule

bind crate_fifo_port cfp_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_func  (cmd_func),
  .cmd_sub   (cmd_sub),
  .rsp_valid (rsp_valid),
  .rsp_q     (rsp_q),
  .lam       (lam),
  .tx_avail  (tx_avail),
  .rx_push   (rx_push),
  .rx_empty  (rx_empty_w),
  .to_flag   (to_flag_w)
);

// File: tb/crate_fifo_port_tb_top.sv
module crate_fifo_port_tb_top;
  localparam int BUS_W = 24;
  localparam int D     = 1024;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, tx_pop, rx_push, link_timeout, link_parity_err;
  logic [4:0] cmd_func;
  logic [3:0] cmd_sub;
  logic [BUS_W-1:0] cmd_wdata;
  logic [7:0] rx_data;
  logic rsp_valid, rsp_q, lam, tx_avail, rx_ready;
  logic [BUS_W-1:0] rsp_rdata;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  crate_fifo_port #(.BUS_W(BUS_W), .DATA_W(8), .FIFO_DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
    .rsp_q(rsp_q), .rsp_rdata(rsp_rdata), .lam(lam), .tx_avail(tx_avail),
    .tx_data(tx_data), .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data),
    .rx_ready(rx_ready), .link_timeout(link_timeout),
    .link_parity_err(link_parity_err)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic m_lam = 1'b0, m_to = 1'b0, m_pe = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] status_of();
    return {2'b00, m_pe, m_to, rxq.size() == D, rxq.size() == 0,
            txq.size() == 0, txq.size() == D};
  endfunction

  task automatic cyc(input logic v, input logic [4:0] f, input logic [3:0] a,
                     input logic [7:0] wd, input logic tp, input logic rp,
                     input logic [7:0] rd, input logic tm, input logic pa);
    logic wr, rdc, st, eq, tx_pushes, rx_pushes, rx_pops;
    logic [BUS_W-1:0] ed;
    string tag;
    wr  = v && f == 5'd16 && a == 4'd0;
    rdc = v && f == 5'd0  && a == 4'd0;
    st  = v && f == 5'd1  && a == 4'd0;
    eq = 1'b0; ed = '0; tag = "R10 other command";
    tx_pushes = 1'b0; rx_pops = 1'b0;
    if (wr) begin
      tx_pushes = !m_to && txq.size() < D;
      eq = tx_pushes;
      tag = m_to ? "R7 write during timeout" :
            (txq.size() == D ? "R3 write to full" : "R2 write");
    end else if (rdc) begin
      rx_pops = rxq.size() > 0;
      eq = rx_pops;
      if (rx_pops) ed = BUS_W'(rxq[0]);
      tag = "R4 read";
    end else if (st) begin
      eq = 1'b1; ed = BUS_W'(status_of()); tag = "R5 status";
    end
    rx_pushes = rp && rxq.size() < D;
    cmd_valid = v; cmd_func = f; cmd_sub = a; cmd_wdata = {16'hA5C3, wd};
    tx_pop = tp; rx_push = rp; rx_data = rd; link_timeout = tm; link_parity_err = pa;
    @(posedge clk); #1;
    // model update (R9: push and pop in one cycle both apply)
    if (tp && txq.size() > 0) void'(txq.pop_front());
    if (tx_pushes) txq.push_back(wd);
    if (rx_pops) void'(rxq.pop_front());
    if (rx_pushes) begin
      if (rxq.size() == 0 && !rx_pops) m_lam = 1'b1;
      rxq.push_back(rd);
    end
    if (rx_pops) m_lam = 1'b0;
    if (rx_pushes && rxq.size() == 1 && !rx_pops) m_lam = 1'b1;
    if (st) begin m_to = 1'b0; m_pe = 1'b0; end
    if (tm) m_to = 1'b1;
    if (pa) m_pe = 1'b1;
    check("R1 rsp_valid", rsp_valid, v);
    if (v) begin
      check(tag, rsp_q, eq);
      check(tag, rsp_rdata, ed);
    end
    check("R6 lam", lam, m_lam);
    check("R2 tx_avail", tx_avail, txq.size() > 0);
    if (txq.size() > 0) check("R2 tx_data order", tx_data, txq[0]);
    check("R11 rx_ready", rx_ready, rxq.size() < D);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(150000 * 5);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    cmd_valid = 0; cmd_func = 0; cmd_sub = 0; cmd_wdata = 0; tx_pop = 0;
    rx_push = 0; rx_data = 0; link_timeout = 0; link_parity_err = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rsp_valid", rsp_valid, 0);
    check("R1 reset lam", lam, 0);
    check("R1 reset tx_avail", tx_avail, 0);
    check("R1 reset rx_ready", rx_ready, 1);
    rst_n = 1'b1;
    idle(1);
    // R5 status of empty port
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R2 writes then link pops
    cyc(1, 16, 0, 8'h11, 0, 0, 0, 0, 0);
    cyc(1, 16, 0, 8'h22, 0, 0, 0, 0, 0);
    cyc(1, 16, 0, 8'h33, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R4 empty read
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 lam on first byte, not on second, cleared by read
    cyc(0, 0, 0, 0, 0, 1, 8'hA1, 0, 0);
    cyc(0, 0, 0, 0, 0, 1, 8'hA2, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 8'hA3, 0, 0);  // R9 push and read together
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 other commands
    cyc(1, 16, 1, 8'h55, 0, 0, 0, 0, 0);
    cyc(1, 2, 0, 8'h55, 0, 0, 0, 0, 0);
    cyc(1, 0, 3, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R7 timeout blocks writes until status read
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    cyc(1, 16, 0, 8'h77, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 16, 0, 8'h78, 0, 0, 0, 0, 0);
    // R8 parity, with pulse coinciding with status read
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 1);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    // R3 / R11 fill transmit buffer
    for (int i = 0; i < D + 2; i++) cyc(1, 16, 0, 8'(i), 0, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 16, 0, 8'hEE, 1, 0, 0, 0, 0);  // full, pop same cycle: refused
    for (int i = 0; i < D + 1; i++) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0);
    // R11 fill receive buffer
    for (int i = 0; i < D + 2; i++) cyc(0, 0, 0, 0, 0, 1, 8'(i * 3), 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, 8'hBB, 0, 0);   // full: push dropped, read taken
    cyc(1, 0, 0, 0, 0, 1, 8'hBC, 0, 0);   // R9 at D-1
    for (int i = 0; i < D + 1; i++) cyc(1, 0, 0, 0, 0, 0, 0, 0, 0);
    // random traffic
    for (int i = 0; i < 6000; i++) begin
      int unsigned r;
      logic [4:0] f;
      logic [3:0] a;
      r = $urandom_range(0, 99);
      f = (r < 35) ? 5'd16 : (r < 70) ? 5'd0 : (r < 85) ? 5'd1 : 5'($urandom_range(0, 31));
      a = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 15)) : 4'd0;
      cyc($urandom_range(0, 3) != 0, f, a, 8'($urandom),
          $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, 8'($urandom),
          $urandom_range(0, 60) == 0, $urandom_range(0, 60) == 0);
    end
    idle(2);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule